// File: doc/BRIEF.md
# Voice Section Playback Sequencer

This block plays one voice section as a stream of 8-bit PCM samples. A section is not stored as one contiguous clip. It is a short list of slices held in an indirection table, and the same slice may be shared by several sections. On a start strobe the block does the following:

- It reads a directory word for the requested section.
- It walks that section's slice entries in order.
- It streams each slice's samples out of a sample memory read port.

Samples are emitted at a programmable rate. A clock divider sets that rate, so a 6 kHz to 20 kHz audio rate can be derived from a fixed core clock.

Playback is framed so that the output never jumps away from or back to the DAC midpoint. Before the first sample, the output ramps linearly from the midpoint toward that sample, one code per sample tick. After the last sample, or when an abort is requested, it ramps back to the midpoint in the same way. The block then releases BUSY. The sample bus carries a one-cycle strobe each time a new value is emitted.

Top module: `voice_seq`

## Requirements
- R1: After reset, and whenever idle, busy_o is 0, sample_o holds the midpoint code 0x80 and sample_stb_o is 0.
- R2: A start_i pulse while idle raises busy_o in the next cycle. The table word at index section_i is a directory word whose low TBL_AW bits give the index of the section's first slice entry.
- R3: While busy, a sample tick occurs every div_i+1 clock cycles. sample_stb_o pulses for exactly one cycle with each new sample_o value, and only while busy_o is 1.
- R4: The ramp-up first emits every code strictly between 0x80 and the section's first sample, stepping by one code per tick. The first sample is emitted on the tick after that. When the first sample is 0x80, it is emitted on the very first tick.
- R5: A slice entry word is {last flag at bit ENT_W-1, start address in bits [LEN_W +: ADDR_W], length in bits [LEN_W-1:0]}. The block emits the samples at start through start+length-1 in address order. It then continues with the next table index, unless the last flag is set. A slice may appear in several sections.
- R6: After the last sample, the output steps by one code per tick toward 0x80 and emits 0x80 itself. The next tick returns the block to idle, so busy_o falls div_i+1 cycles after the final strobe. This also holds when the last sample is already 0x80.
- R7: abort_i while busy makes the block enter the ramp-down in the next cycle, starting from the current output value. abort_i while idle has no effect.
- R8: start_i while busy is ignored, and the section already playing continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| section_i | input | SEC_W | Section number sampled with start_i |
| abort_i | input | 1 | Abort request |
| div_i | input | DIV_W | Sample tick divider; period is div_i+1 cycles |
| tbl_rd_o | output | 1 | Table read enable |
| tbl_addr_o | output | TBL_AW | Table read index |
| tbl_data_i | input | 1+ADDR_W+LEN_W | Table word, valid one cycle after the read |
| mem_rd_o | output | 1 | Sample memory read enable |
| mem_addr_o | output | ADDR_W | Sample memory address |
| mem_data_i | input | SMP_W | Sample word, valid one cycle after the read |
| sample_o | output | SMP_W | Current output code |
| sample_stb_o | output | 1 | One-cycle pulse on each new output value |
| busy_o | output | 1 | High while a section or its ramps are in progress |

## Verification
The assertions assume the following about the inputs:

- Both read ports return data exactly one cycle after the read.
- div_i is at least 7 and does not change during playback, so every table and sample fetch completes between two ticks.
- Every slice has a non-zero length.
- Every section's entry chain ends in a last flag.

The bench models both memories with that one-cycle latency and uses only divider values of 7 or more. Its table holds only terminated chains of slices of length 2 to 4, and it changes the divider only while the block is idle.

// File: rtl/voice_seq_pkg.sv
package voice_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_WT,
    ST_ENT_RD,
    ST_ENT_WT,
    ST_SMP_RD,
    ST_SMP_WT,
    ST_RAMP_UP,
    ST_PLAY,
    ST_RAMP_DN
  } seq_state_e;
endpackage

// File: rtl/voice_seq_tick.sv
module voice_seq_tick #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i)             cnt_q <= div_i;
    else if (cnt_q == '0)        cnt_q <= div_i;
    else                         cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = run_i && (cnt_q == '0);

  // R3
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/voice_seq_ramp.sv
module voice_seq_ramp #(
  parameter int SMP_W = 8
) (
  input  logic [SMP_W-1:0] cur_i,
  input  logic [SMP_W-1:0] tgt_i,
  output logic [SMP_W-1:0] nxt_o,
  output logic             eq_o,
  output logic             nxt_eq_o
);
  always_comb begin
    if (cur_i < tgt_i)      nxt_o = cur_i + 1'b1;
    else if (cur_i > tgt_i) nxt_o = cur_i - 1'b1;
    else                    nxt_o = cur_i;
  end

  assign eq_o     = (cur_i == tgt_i);
  assign nxt_eq_o = (nxt_o == tgt_i);
endmodule

// File: rtl/voice_seq_ctrl.sv
module voice_seq_ctrl
  import voice_seq_pkg::*;
#(
  parameter int SEC_W  = 3,
  parameter int TBL_AW = 5,
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8,
  parameter int SMP_W  = 8,
  localparam int ENT_W = 1 + ADDR_W + LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SEC_W-1:0]  section_i,
  input  logic              abort_i,
  input  logic              tick_i,
  output logic              tbl_rd_o,
  output logic [TBL_AW-1:0] tbl_addr_o,
  input  logic [ENT_W-1:0]  tbl_data_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [SMP_W-1:0]  mem_data_i,
  output logic [SMP_W-1:0]  sample_o,
  output logic              stb_o,
  output logic              busy_o
);
  localparam logic [SMP_W-1:0] MID_CODE = SMP_W'(1) << (SMP_W - 1);

  seq_state_e        state_q, state_d;
  logic [SEC_W-1:0]  sec_q, sec_d;
  logic [TBL_AW-1:0] ent_q, ent_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              last_q, last_d;
  logic              primed_q, primed_d;
  logic [SMP_W-1:0]  smp_q, smp_d;
  logic [SMP_W-1:0]  out_q, out_d;
  logic              stb_q, stb_d;

  logic [SMP_W-1:0]  ramp_tgt, ramp_nxt;
  logic              ramp_eq, ramp_nxt_eq;

  assign ramp_tgt = (state_q == ST_RAMP_UP) ? smp_q : MID_CODE;

  voice_seq_ramp #(.SMP_W(SMP_W)) u_ramp (
    .cur_i    (out_q),
    .tgt_i    (ramp_tgt),
    .nxt_o    (ramp_nxt),
    .eq_o     (ramp_eq),
    .nxt_eq_o (ramp_nxt_eq)
  );

  always_comb begin
    state_d  = state_q;
    sec_d    = sec_q;
    ent_d    = ent_q;
    addr_d   = addr_q;
    rem_d    = rem_q;
    last_d   = last_q;
    primed_d = primed_q;
    smp_d    = smp_q;
    out_d    = out_q;
    stb_d    = 1'b0;

    unique case (state_q)
      ST_IDLE: if (start_i) begin
        sec_d    = section_i;
        primed_d = 1'b0;
        state_d  = ST_DIR_RD;
      end
      ST_DIR_RD: state_d = ST_DIR_WT;
      ST_DIR_WT: begin
        ent_d   = tbl_data_i[TBL_AW-1:0];
        state_d = ST_ENT_RD;
      end
      ST_ENT_RD: state_d = ST_ENT_WT;
      ST_ENT_WT: begin
        last_d  = tbl_data_i[ENT_W-1];
        addr_d  = tbl_data_i[LEN_W +: ADDR_W];
        rem_d   = tbl_data_i[LEN_W-1:0];
        ent_d   = ent_q + 1'b1;
        state_d = ST_SMP_RD;
      end
      ST_SMP_RD: state_d = ST_SMP_WT;
      ST_SMP_WT: begin
        smp_d   = mem_data_i;
        addr_d  = addr_q + 1'b1;
        state_d = primed_q ? ST_PLAY : ST_RAMP_UP;
      end
      ST_RAMP_UP, ST_PLAY: if (tick_i) begin
        stb_d = 1'b1;
        if (state_q == ST_RAMP_UP && !ramp_eq && !ramp_nxt_eq) begin
          out_d = ramp_nxt;
        end else begin
          out_d    = smp_q;
          primed_d = 1'b1;
          if (rem_q <= LEN_W'(1)) begin
            state_d = last_q ? ST_RAMP_DN : ST_ENT_RD;
          end else begin
            rem_d   = rem_q - 1'b1;
            state_d = ST_SMP_RD;
          end
        end
      end
      ST_RAMP_DN: if (tick_i) begin
        if (ramp_eq) begin
          state_d = ST_IDLE;
        end else begin
          out_d = ramp_nxt;
          stb_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase

    // abort overrides any pending emission
    if (abort_i && state_q != ST_IDLE && state_q != ST_RAMP_DN) begin
      state_d = ST_RAMP_DN;
      out_d   = out_q;
      stb_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sec_q    <= '0;
      ent_q    <= '0;
      addr_q   <= '0;
      rem_q    <= '0;
      last_q   <= 1'b0;
      primed_q <= 1'b0;
      smp_q    <= MID_CODE;
      out_q    <= MID_CODE;
      stb_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      sec_q    <= sec_d;
      ent_q    <= ent_d;
      addr_q   <= addr_d;
      rem_q    <= rem_d;
      last_q   <= last_d;
      primed_q <= primed_d;
      smp_q    <= smp_d;
      out_q    <= out_d;
      stb_q    <= stb_d;
    end
  end

  assign tbl_rd_o   = (state_q == ST_DIR_RD) || (state_q == ST_ENT_RD);
  assign tbl_addr_o = (state_q == ST_DIR_RD) ? TBL_AW'(sec_q) : ent_q;
  assign mem_rd_o   = (state_q == ST_SMP_RD);
  assign mem_addr_o = addr_q;
  assign sample_o   = out_q;
  assign stb_o      = stb_q;
  assign busy_o     = (state_q != ST_IDLE);

  // R1
  idle_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (out_q == MID_CODE && !stb_q));
  // R2
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q == ST_IDLE) |=> busy_o);
  // R3
  stb_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> busy_o);
  // R4
  ramp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_q && ($past(state_q) == ST_RAMP_UP || $past(state_q) == ST_RAMP_DN)) |->
    (out_q == $past(out_q) || (out_q - $past(out_q)) == SMP_W'(1) ||
     ($past(out_q) - out_q) == SMP_W'(1)));
  // R7
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && state_q != ST_IDLE) |=> (state_q == ST_RAMP_DN || state_q == ST_IDLE));
  // R8
  retrig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state_q != ST_IDLE) |=> $stable(sec_q));
endmodule

// File: rtl/voice_seq.sv
module voice_seq #(
  parameter int SEC_W  = 3,
  parameter int TBL_AW = 5,
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 8,
  parameter int SMP_W  = 8,
  parameter int DIV_W  = 12,
  localparam int ENT_W = 1 + ADDR_W + LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SEC_W-1:0]  section_i,
  input  logic              abort_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              tbl_rd_o,
  output logic [TBL_AW-1:0] tbl_addr_o,
  input  logic [ENT_W-1:0]  tbl_data_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [SMP_W-1:0]  mem_data_i,
  output logic [SMP_W-1:0]  sample_o,
  output logic              sample_stb_o,
  output logic              busy_o
);
  logic tick;

  voice_seq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .div_i  (div_i),
    .tick_o (tick)
  );

  voice_seq_ctrl #(
    .SEC_W (SEC_W), .TBL_AW(TBL_AW), .ADDR_W(ADDR_W),
    .LEN_W (LEN_W), .SMP_W (SMP_W)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .section_i  (section_i),
    .abort_i    (abort_i),
    .tick_i     (tick),
    .tbl_rd_o   (tbl_rd_o),
    .tbl_addr_o (tbl_addr_o),
    .tbl_data_i (tbl_data_i),
    .mem_rd_o   (mem_rd_o),
    .mem_addr_o (mem_addr_o),
    .mem_data_i (mem_data_i),
    .sample_o   (sample_o),
    .stb_o      (sample_stb_o),
    .busy_o     (busy_o)
  );
endmodule

// File: tb/voice_seq_tb.sv
module voice_seq_tb;
  localparam int SEC_W = 3, TBL_AW = 5, ADDR_W = 12, LEN_W = 8, SMP_W = 8, DIV_W = 12;
  localparam int ENT_W = 1 + ADDR_W + LEN_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0;
  logic [SEC_W-1:0] section = '0;
  logic [DIV_W-1:0] div = 12'd9;
  logic tbl_rd, mem_rd, stb, busy;
  logic [TBL_AW-1:0] tbl_addr;
  logic [ENT_W-1:0] tbl_data;
  logic [ADDR_W-1:0] mem_addr;
  logic [SMP_W-1:0] mem_data, sample;

  always #2 clk = ~clk;

  voice_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .section_i(section), .abort_i(abort),
    .div_i(div), .tbl_rd_o(tbl_rd), .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_data),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .sample_o(sample), .sample_stb_o(stb), .busy_o(busy)
  );

  function automatic logic [7:0] smp_of(input logic [ADDR_W-1:0] a);
    return 8'(a[7:0] + 8'h70);
  endfunction

  function automatic logic [ENT_W-1:0] mk(input logic lst, input int st, input int len);
    return {lst, ADDR_W'(st), LEN_W'(len)};
  endfunction

  logic [ENT_W-1:0] tbl_mem [32];
  initial begin
    for (int i = 0; i < 32; i++) tbl_mem[i] = '0;
    // directory words
    tbl_mem[0] = 21'd8;  tbl_mem[1] = 21'd9;  tbl_mem[2] = 21'd11; tbl_mem[3] = 21'd13;
    for (int i = 4; i < 8; i++) tbl_mem[i] = 21'd8;
    // slices: A=0x10/4, B=0x20/3, C=0x05/2, D=0x0E/3
    tbl_mem[8]  = mk(1'b1, 'h10, 4);
    tbl_mem[9]  = mk(1'b0, 'h20, 3);
    tbl_mem[10] = mk(1'b1, 'h10, 4);
    tbl_mem[11] = mk(1'b0, 'h05, 2);
    tbl_mem[12] = mk(1'b1, 'h0E, 3);
    tbl_mem[13] = mk(1'b0, 'h0E, 3);
    tbl_mem[14] = mk(1'b0, 'h20, 3);
    tbl_mem[15] = mk(1'b1, 'h05, 2);
  end

  always_ff @(posedge clk) begin
    if (tbl_rd) tbl_data <= tbl_mem[tbl_addr];
    if (mem_rd) mem_data <= smp_of(mem_addr);
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int ncap = 0;
  logic [7:0] cap_v [512];
  int cap_c [512];
  always @(negedge clk) if (stb && ncap < 512) begin
    cap_v[ncap] = sample;
    cap_c[ncap] = cyc;
    ncap = ncap + 1;
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  int nexp;
  logic [7:0] exp_v [512];

  task automatic build_exp(input int sec);
    int idx;
    logic [7:0] smps [64];
    int ns;
    logic [7:0] v;
    logic [ENT_W-1:0] e;
    ns = 0;
    idx = int'(tbl_mem[sec][TBL_AW-1:0]);
    forever begin
      e = tbl_mem[idx];
      for (int k = 0; k < int'(e[LEN_W-1:0]); k++) begin
        smps[ns] = smp_of(e[LEN_W +: ADDR_W] + ADDR_W'(k));
        ns++;
      end
      if (e[ENT_W-1]) break;
      idx++;
    end
    nexp = 0;
    v = 8'h80;
    while (v != smps[0]) begin
      v = (v < smps[0]) ? v + 8'd1 : v - 8'd1;
      if (v == smps[0]) break;
      exp_v[nexp] = v; nexp++;
    end
    for (int k = 0; k < ns; k++) begin exp_v[nexp] = smps[k]; nexp++; end
    v = smps[ns-1];
    while (v != 8'h80) begin
      v = (v > 8'h80) ? v - 8'd1 : v + 8'd1;
      exp_v[nexp] = v; nexp++;
    end
  endtask

  int idle_cyc;
  task automatic wait_idle();
    int n;
    n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    idle_cyc = cyc;
  endtask

  task automatic kick(input int sec);
    ncap = 0;
    @(negedge clk);
    start = 1'b1; section = SEC_W'(sec);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
  endtask

  task automatic cmp_stream(input string tag);
    int bad;
    bad = 0;
    chk(ncap == nexp, {tag, " count"}, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++) begin
      if (cap_v[i] != exp_v[i]) begin
        if (bad == 0) chk(1'b0, {tag, " value"}, int'(cap_v[i]), int'(exp_v[i]));
        bad++;
      end
    end
    if (bad == 0) chk(1'b1, tag, 0, 0);
  endtask

  // {section, divider}
  localparam logic [14:0] VECS [6] = '{
    {3'd0, 12'd9}, {3'd1, 12'd7}, {3'd2, 12'd12},
    {3'd3, 12'd8}, {3'd1, 12'd20}, {3'd5, 12'd7}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(sample == 8'h80, "R1 sample in reset", int'(sample), 'h80);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(stb == 1'b0 && sample == 8'h80, "R1 idle after reset", int'(sample), 'h80);

    for (int v = 0; v < 6; v++) begin
      int sec, dv, badp;
      sec = int'(VECS[v][14:12]);
      dv  = int'(VECS[v][11:0]);
      div = DIV_W'(dv);
      build_exp(sec);
      kick(sec);
      wait_idle();
      // R4 R5 R6 stream shape
      cmp_stream("R4 R5 R6 stream");
      badp = 0;
      for (int i = 1; i < ncap; i++)
        if (cap_c[i] - cap_c[i-1] != dv + 1) badp++;
      chk(badp == 0, "R3 tick period", badp, 0);
      if (ncap > 0)
        chk(idle_cyc - cap_c[ncap-1] == dv + 1, "R6 busy fall timing",
            idle_cyc - cap_c[ncap-1], dv + 1);
      chk(sample == 8'h80, "R1 idle midpoint", int'(sample), 'h80);
    end

    // R7 abort while idle has no effect
    ncap = 0;
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b0 && ncap == 0, "R7 abort idle ignored", ncap, 0);

    // R7 abort during ramp-up
    div = 12'd7;
    kick(1);
    while (ncap < 5 && busy) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    wait_idle();
    nexp = 0;
    for (int k = 0; k < 5; k++) begin exp_v[nexp] = 8'(8'h81 + k); nexp++; end
    for (int k = 0; k < 5; k++) begin exp_v[nexp] = 8'(8'h84 - k); nexp++; end
    cmp_stream("R7 abort ramp-down");

    // R8 start while busy ignored
    div = 12'd9;
    build_exp(0);
    kick(0);
    while (ncap < 3 && busy) @(negedge clk);
    start = 1'b1; section = 3'd3;
    @(negedge clk); start = 1'b0;
    wait_idle();
    cmp_stream("R8 retrigger ignored");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule